// File: doc/BRIEF.md
# Modulo and Bit-Reversed Address Generator

This block computes the memory address for a load or store and the value the pointer register takes afterwards. It is fed a 3-bit mode, an access-size flag (byte or halfword), a 32-bit pointer or index register, a 32-bit immediate, a 2-bit shift amount, and two modifier/start register pairs. A select bit picks which pair is used. It returns the effective address, the next pointer and a pointer write enable. The memory access itself happens elsewhere.

There are eight modes. Two address memory without touching the pointer: base plus offset, and shifted index plus constant. One loads a constant address and also writes it to the pointer. Five are post-increment modes: by the modifier register, by the modifier with a bit-reversed address, by the immediate, and two circular variants that wrap the pointer inside a buffer described by the start register and a length. In the post-increment modes the address is the pointer value before the update.

The datapath is combinational. With the `REG_OUT` parameter set (default 1), the three outputs are registered, which gives one cycle of latency and a reset value of zero.

Top module: `agu_modbrev`

## Requirements
- R1: While `rst_n` is low, and with `REG_OUT=1`, the outputs `ea`, `next_ptr` and `ptr_we` are all zero. Results appear one clock after the inputs are presented.
- R2: Mode 0 (offset): `ea = ptr + imm` and `ptr_we = 0`.
- R3: Mode 1 (shifted index): `ea = (ptr << shamt) + imm` and `ptr_we = 0`. With shift 1, indices 0..3 give offsets 0, 2, 4, 6.
- R4: Mode 2 (absolute): `ea = imm`, `next_ptr = imm`, `ptr_we = 1`.
- R5: In modes 3 and 5 to 7 (post-increment), `ea` equals the incoming `ptr` and `ptr_we = 1`.
- R6: Mode 3: `next_ptr = ptr + mod`. Mode 5: `next_ptr = ptr + imm`.
- R7: Mode 4 (bit-reversed): `ea[15:0]` is `ptr[15:0]` with its bit order reversed, `ea[31:16] = ptr[31:16]`, `next_ptr = ptr + mod`, `ptr_we = 1`. With `mod = 0x2000`, successive accesses reach offsets 0, 4, 2, 6.
- R8: Mode 6 (circular, immediate step): the step is `imm` and the length is `mod[16:0]`. `next_ptr = start + ((ptr - start + imm) mod len)`, where the step is less than the length. A length of 2 with a step of 1 alternates between offsets 0 and 1.
- R9: Mode 7 (circular, register step): the step is `mod[23:17]`, shifted left by 1 when `half` is 1. The length is `mod[16:0]`, and the same wrap as R8 applies. For a halfword access with length 4 and step field 1, the pointer goes through offsets 2, 0, 2, 0.
- R10: In modes 6 and 7, a length of zero disables the wrap: `next_ptr = ptr + step`.
- R11: `psel = 0` takes `mod0`/`start0`, and `psel = 1` takes `mod1`/`start1`. This applies in every mode that reads a modifier or start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Addressing mode 0..7 |
| half | input | 1 | Access size: 0 byte, 1 halfword |
| ptr | input | 32 | Pointer, base or index register |
| imm | input | 32 | Offset, constant base, absolute address or step |
| shamt | input | 2 | Index shift for mode 1 |
| psel | input | 1 | Modifier/start pair select |
| mod0 | input | 32 | Modifier register, pair 0 |
| start0 | input | 32 | Circular start register, pair 0 |
| mod1 | input | 32 | Modifier register, pair 1 |
| start1 | input | 32 | Circular start register, pair 1 |
| ea | output | 32 | Effective address |
| next_ptr | output | 32 | Updated pointer value |
| ptr_we | output | 1 | Pointer write enable |

## Verification
The bench sweeps every wrap case for lengths 1 to 8: all steps and starting offsets, in both access sizes. A design whose comparison is off by one would land on `start + len` rather than `start`. A design that forgot the halfword scaling would step by half the distance in mode 7. It also walks a large stride through the 16-bit bit-reversal field, which exposes a swapped or shifted bit order. It checks that the upper address bits pass through unchanged. A zero length must add the step plainly; a design that divided by zero or still wrapped would produce nonsense there. Each mode is also run with the other pair selected, so a pair-select wiring error shows up as a wrong pointer.

// File: rtl/agu_modbrev.sv
module agu_modbrev #(
  parameter int AW      = 32,
  parameter int REV_W   = 16,
  parameter int LEN_W   = 17,
  parameter int STEP_W  = 7,
  parameter int SH_W    = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          half,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] imm,
  input  logic [SH_W-1:0] shamt,
  input  logic          psel,
  input  logic [AW-1:0] mod0,
  input  logic [AW-1:0] start0,
  input  logic [AW-1:0] mod1,
  input  logic [AW-1:0] start1,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] next_ptr,
  output logic          ptr_we
);

  localparam int STEP_HI = LEN_W + STEP_W - 1;

  logic [AW-1:0] md, st;
  assign md = psel ? mod1 : mod0;
  assign st = psel ? start1 : start0;

  logic [AW-1:0] brev;
  assign brev[AW-1:REV_W] = ptr[AW-1:REV_W];
  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign brev[i] = ptr[REV_W-1-i];
  end

  logic [AW-1:0] len, rstep, cstep, off, sum, wsum;
  logic          wrap;
  assign len   = AW'(md[LEN_W-1:0]);
  assign rstep = AW'(md[STEP_HI:LEN_W]) << half;
  assign cstep = mode[0] ? rstep : imm;
  assign off   = ptr - st;
  assign sum   = off + cstep;
  assign wrap  = (len != '0) && (sum >= len);
  assign wsum  = wrap ? sum - len : sum;

  logic [AW-1:0] ea_c, np_c;
  logic          we_c;
  always_comb begin
    ea_c = ptr;
    np_c = ptr;
    we_c = 1'b1;
    case (mode)
      3'd0: begin ea_c = ptr + imm; we_c = 1'b0; end
      3'd1: begin ea_c = (ptr << shamt) + imm; we_c = 1'b0; end
      3'd2: begin ea_c = imm; np_c = imm; end
      3'd3: np_c = ptr + md;
      3'd4: begin ea_c = brev; np_c = ptr + md; end
      3'd5: np_c = ptr + imm;
      default: np_c = st + wsum;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ea <= '0; next_ptr <= '0; ptr_we <= 1'b0;
      end else begin
        ea <= ea_c; next_ptr <= np_c; ptr_we <= we_c;
      end
    end
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (ea == '0 && next_ptr == '0 && !ptr_we)); // R1
  end else begin : g_comb
    assign ea = ea_c;
    assign next_ptr = np_c;
    assign ptr_we = we_c;
  end

  AST_NOWRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd1) |-> !we_c); // R2
  AST_ABS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (np_c == ea_c && ea_c == imm)); // R4
  AST_POSTINC_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 || mode >= 3'd5) |-> (ea_c == ptr && we_c)); // R5
  AST_BREV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (ea_c[AW-1:REV_W] == ptr[AW-1:REV_W] && ea_c[0] == ptr[REV_W-1])); // R7
  AST_CIRC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd6 && len != '0 && (ptr - st) < len && cstep < len) |-> ((np_c - st) < len)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd6 && len == '0) |-> (np_c == ptr + cstep)); // R10

endmodule

// File: tb/tb_agu_modbrev.sv
`timescale 1ns/1ps
module tb_agu_modbrev;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic half = 1'b0, psel = 1'b0;
  logic [31:0] ptr = '0, imm = '0, mod0 = '0, start0 = '0, mod1 = '0, start1 = '0;
  logic [1:0] shamt = '0;
  logic [31:0] ea, next_ptr;
  logic ptr_we;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  agu_modbrev dut (.clk(clk), .rst_n(rst_n), .mode(mode), .half(half), .ptr(ptr),
    .imm(imm), .shamt(shamt), .psel(psel), .mod0(mod0), .start0(start0),
    .mod1(mod1), .start1(start1), .ea(ea), .next_ptr(next_ptr), .ptr_we(ptr_we));

  function automatic logic [31:0] rev16(input logic [31:0] a);
    logic [31:0] r = a;
    for (int i = 0; i < 16; i++) r[i] = a[15-i];
    return r;
  endfunction

  function automatic logic [64:0] model(input logic [2:0] m, input logic h,
      input logic [31:0] p, input logic [31:0] im, input logic [1:0] sh,
      input logic [31:0] md, input logic [31:0] st);
    logic [31:0] e, n, ln, sp, o;
    logic w;
    e = p; n = p; w = 1'b1;
    ln = {15'd0, md[16:0]};
    sp = (m == 3'd7) ? ({25'd0, md[23:17]} * (h ? 32'd2 : 32'd1)) : im;
    case (m)
      3'd0: begin e = p + im; w = 1'b0; end
      3'd1: begin e = p * (32'd1 << sh) + im; w = 1'b0; end
      3'd2: begin e = im; n = im; end
      3'd3: n = p + md;
      3'd4: begin e = rev16(p); n = p + md; end
      3'd5: n = p + im;
      default: begin
        o = p - st;
        n = (ln == 0) ? p + sp : st + ((o + sp) % ln);
      end
    endcase
    return {w, e, n};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] m, input logic h,
      input logic [31:0] p, input logic [31:0] im, input logic [1:0] sh, input logic ps);
    logic [64:0] x;
    @(negedge clk);
    mode = m; half = h; ptr = p; imm = im; shamt = sh; psel = ps;
    x = model(m, h, p, im, sh, ps ? mod1 : mod0, ps ? start1 : start0);
    @(posedge clk); #1;
    check(tag, "ea", ea, x[63:32]);
    check(tag, "next_ptr", next_ptr, x[31:0]);
    check(tag, "ptr_we", {31'd0, ptr_we}, {31'd0, x[64]});
  endtask

  task automatic chain(input string tag, input logic [2:0] m, input logic h,
      input logic [31:0] base, input logic [31:0] im, input int exp_off[4], input logic ps);
    logic [31:0] p = base;
    for (int k = 0; k < 4; k++) begin
      apply(tag, m, h, p, im, 2'd0, ps);
      check(tag, "seq offset", (m == 3'd4 ? ea : next_ptr) - base, exp_off[k]);
      p = next_ptr;
    end
  endtask

  initial begin
    #20000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1", "ea reset", ea, 0);
    check("R1", "next_ptr reset", next_ptr, 0);
    check("R1", "we reset", {31'd0, ptr_we}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 16; i++) apply("R2", 3'd0, 1'b0, 32'h1000_0000 + i, 32'(i * 37), 2'd0, 1'b0);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8; i++) apply("R3", 3'd1, 1'b0, 32'(i), 32'h0001_0000, 2'(s), 1'b0);
    for (int i = 0; i < 4; i++) begin
      apply("R3", 3'd1, 1'b0, 32'(i), 32'h0004_0000, 2'd1, 1'b0);
      check("R3", "shift-1 offset", ea - 32'h0004_0000, 32'(2 * i));
    end
    apply("R4", 3'd2, 1'b0, 32'h1234_5678, 32'hdead_0010, 2'd0, 1'b0);
    apply("R4", 3'd2, 1'b1, 32'h0, 32'h0001_0003, 2'd0, 1'b1);

    mod0 = 32'd2; mod1 = 32'h0000_2000;
    start0 = 32'h0002_0000; start1 = 32'h0003_0000;
    for (int i = 0; i < 8; i++) begin
      apply("R5", 3'd3, i[0], 32'h0005_0000 + i, 32'd0, 2'd0, i[1]);
      apply("R6", 3'd5, i[0], 32'h0005_0000 + i, 32'(i + 1), 2'd0, i[1]);
    end
    chain("R7", 3'd4, 1'b0, 32'h0007_0000, 32'd0, '{0, 4, 2, 6}, 1'b1);
    chain("R7", 3'd4, 1'b1, 32'h0007_0000, 32'd0, '{0, 4, 2, 6}, 1'b1);
    for (int p = 0; p < 65536; p += 13) apply("R7", 3'd4, 1'b0, 32'h5a5a_0000 + 32'(p), 32'd0, 2'd0, 1'b1);

    mod0 = 32'd2; start0 = 32'h0002_0000;
    chain("R8", 3'd6, 1'b0, 32'h0002_0000, 32'd1, '{1, 0, 1, 0}, 1'b0);
    mod1 = (32'd1 << 17) | 32'd4; start1 = 32'h0003_0000;
    chain("R9", 3'd7, 1'b1, 32'h0003_0000, 32'd0, '{2, 0, 2, 0}, 1'b1);

    for (int ln = 1; ln <= 8; ln++)
      for (int sp = 0; sp < ln; sp++)
        for (int o = 0; o < ln; o++) begin
          mod0 = 32'(ln); start0 = 32'h0009_0100;
          apply("R8", 3'd6, 1'b0, start0 + 32'(o), 32'(sp), 2'd0, 1'b0);
          for (int h = 0; h < 2; h++) begin
            if ((sp << h) < ln) begin
              mod1 = (32'(sp) << 17) | 32'(ln); start1 = 32'h000a_0200;
              apply("R9", 3'd7, h[0], start1 + 32'(o), 32'd0, 2'd0, 1'b1);
            end
          end
        end

    mod0 = 32'h00fe_0000; start0 = 32'h0001_0000;
    apply("R10", 3'd6, 1'b0, 32'h0001_0040, 32'd9, 2'd0, 1'b0);
    check("R10", "no wrap imm", next_ptr, 32'h0001_0049);
    apply("R10", 3'd7, 1'b1, 32'h0001_0040, 32'd0, 2'd0, 1'b0);
    check("R10", "no wrap reg", next_ptr, 32'h0001_0040 + 32'd254);

    mod0 = 32'd3; mod1 = 32'd100; start0 = 32'h10; start1 = 32'h0;
    apply("R11", 3'd3, 1'b0, 32'h100, 32'd0, 2'd0, 1'b0);
    check("R11", "pair0 mod", next_ptr, 32'h103);
    apply("R11", 3'd3, 1'b0, 32'h100, 32'd0, 2'd0, 1'b1);
    check("R11", "pair1 mod", next_ptr, 32'h164);
    mod0 = 32'd4; mod1 = 32'd4; start0 = 32'h10; start1 = 32'h20;
    apply("R11", 3'd6, 1'b0, 32'h13, 32'd2, 2'd0, 1'b0);
    check("R11", "pair0 start", next_ptr, 32'h11);
    apply("R11", 3'd6, 1'b0, 32'h23, 32'd2, 2'd0, 1'b1);
    check("R11", "pair1 start", next_ptr, 32'h21);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule